// File: doc/BRIEF.md
# Bus Access Permission Checker

This block sits in front of memories and peripheral registers and rules on every bus access before it reaches its target. Each access arrives with the requester's master identifier, its security mode (one trusted mode and three less-trusted modes), a target address, an access type (read, write or execute) and the verdict of the CPU-side protection unit. Boot ROM and internal SRAM addresses skip the region check and only follow the CPU-side verdict. For other addresses, a failed CPU-side verdict blocks the access and the region check does not run. If the verdict passed, the address is matched against sixteen configurable regions, and the matching region's permission bits for the requester's mode decide the outcome.

For accesses issued by the CPU, a small helper derives the security mode from the privilege level. Machine privilege always maps to the trusted mode. User privilege maps to one less-trusted mode chosen by a configuration register. Other masters supply their own mode. When the region check blocks an access, the block keeps a record of it: master, mode, address and a reason code that tells an unmapped address from a missing permission. An interrupt follows the record when it is enabled.

The request side has no back-pressure. The block always takes a request in the cycle it is valid and returns exactly one of allow or deny in that same cycle, combinationally. The requester may change or drop the request on any cycle. Configuration writes are single-cycle strobes and are never stalled.

Top module: `bus_perm_guard`

## Requirements
- R1: The effective security mode is 0 (trusted) for a CPU access in machine privilege (`req_is_cpu`=1, `req_cpu_machine`=1). For a CPU access in user privilege it is the user-mode register. For any other master it is `req_mode`. Writing 0 to the user-mode register stores 1, so the register only ever holds 1, 2 or 3. It resets to 1.
- R2: An address in boot ROM [0x4000_0000, 0x4001_FFFF] or internal SRAM [0x4080_0000, 0x408F_FFFF] (default bounds) is allowed exactly when `req_pmp_ok`=1, and it never creates a violation record.
- R3: For any other address with `req_pmp_ok`=0, the access is denied and no violation record is created.
- R4: A region matches when its enable bit (bit 12 of the permission word) is 1 and start <= address <= end, with both bounds inclusive. An address that matches no enabled region is denied with reason code 1. After reset every region is disabled.
- R5: When several enabled regions match, the lowest-numbered one alone decides the outcome.
- R6: Permission word bit 3*m+0 grants read, bit 3*m+1 grants write and bit 3*m+2 grants execute to mode m. Access type codes are 0 read, 1 write, 2 execute. Code 3 is never granted. A matching region without the needed bit denies with reason code 2.
- R7: While `req_valid`=1, exactly one of `dec_allow` and `dec_deny` is 1 in that same cycle. While `req_valid`=0, both are 0.
- R8: On the clock edge after a region-check denial, an empty record captures master, mode, address and reason and sets `rec_valid`. A denial while the record is full only sets `rec_ovf`. `rec_clr` empties the record and clears `rec_ovf`; a denial in the same cycle as `rec_clr` is captured as a fresh record.
- R9: `irq` is 1 exactly when `irq_en`=1 and `rec_valid`=1.
- R10: On a configuration write (`cfg_we`=1), field code 0 writes the start address, 1 the end address and 2 the 13-bit permission word of region `cfg_idx`. Field code 3 writes the user-mode register from `cfg_wdata[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Region number for the write |
| cfg_field | input | 2 | Field code: 0 start, 1 end, 2 permissions, 3 user mode |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | An access is presented this cycle |
| req_mid | input | 4 | Master identifier |
| req_is_cpu | input | 1 | Access comes from the CPU |
| req_cpu_machine | input | 1 | CPU is in machine privilege |
| req_mode | input | 2 | Security mode supplied by a non-CPU master |
| req_addr | input | 32 | Access address |
| req_type | input | 2 | 0 read, 1 write, 2 execute |
| req_pmp_ok | input | 1 | CPU-side protection verdict |
| dec_allow | output | 1 | Access allowed |
| dec_deny | output | 1 | Access blocked |
| irq_en | input | 1 | Interrupt enable |
| rec_clr | input | 1 | Empty the violation record |
| irq | output | 1 | Violation interrupt |
| rec_valid | output | 1 | Record holds a violation |
| rec_ovf | output | 1 | A further violation came while the record was full |
| rec_mid | output | 4 | Recorded master identifier |
| rec_mode | output | 2 | Recorded security mode |
| rec_addr | output | 32 | Recorded address |
| rec_reason | output | 2 | 1 no region, 2 permission |

## Verification
The hardest situations to reach from the ports are the ones where the record must stay put or stay empty. Examples are a CPU-side failure or a bypassed-address denial that must leave no trace, a second violation that may only raise the overflow flag, and a clear that meets a new violation in the same cycle. The stimulus handles this in a fixed order. It first empties the record, then presents the denial that must leave no trace, and reads the record flags on the following cycle. It then creates a real violation and stacks a second violation on the full record. Finally it pulses the clear together with a third violation and checks that the fresh fields replace the old ones. The effective mode of CPU accesses is not visible directly. It is read back through the recorded mode of deliberate violations.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int NUM_MODES = 4;
  localparam int ENA_BIT   = 3 * NUM_MODES;
  localparam int PERM_W    = ENA_BIT + 1;

  localparam logic [1:0] MODE_TRUSTED = 2'd0;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam logic [1:0] RSN_NONE     = 2'd0;
  localparam logic [1:0] RSN_NOREGION = 2'd1;
  localparam logic [1:0] RSN_PERM     = 2'd2;

  localparam logic [1:0] FLD_LO   = 2'd0;
  localparam logic [1:0] FLD_HI   = 2'd1;
  localparam logic [1:0] FLD_PERM = 2'd2;
  localparam logic [1:0] FLD_UMOD = 2'd3;
endpackage

// File: rtl/bpg_mode_sel.sv
module bpg_mode_sel
  import bpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_field,
  input  logic [1:0] cfg_mode,
  input  logic       req_is_cpu,
  input  logic       req_cpu_machine,
  input  logic [1:0] req_mode,
  output logic [1:0] eff_mode
);
  logic [1:0] user_mode_q;

  // R1: user-mode register; 0 is replaced by 1 so it always names a less-trusted mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_mode_q <= 2'd1;
    end else if (cfg_we && cfg_field == FLD_UMOD) begin
      user_mode_q <= (cfg_mode == MODE_TRUSTED) ? 2'd1 : cfg_mode;
    end
  end

  always_comb begin
    if (!req_is_cpu)          eff_mode = req_mode;
    else if (req_cpu_machine) eff_mode = MODE_TRUSTED;
    else                      eff_mode = user_mode_q;
  end
endmodule

// File: rtl/bpg_region_file.sv
module bpg_region_file
  import bpg_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_field,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     rgn_lo   [NREG],
  output logic [AW-1:0]     rgn_hi   [NREG],
  output logic [PERM_W-1:0] rgn_perm [NREG]
);
  // R10: one write strobe, field code picks the register, region number picks the slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rgn_lo[i]   <= '0;
        rgn_hi[i]   <= '0;
        rgn_perm[i] <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NREG; i++) begin
        if (cfg_idx == IDX_W'(i)) begin
          case (cfg_field)
            FLD_LO:   rgn_lo[i]   <= cfg_wdata;
            FLD_HI:   rgn_hi[i]   <= cfg_wdata;
            FLD_PERM: rgn_perm[i] <= cfg_wdata[PERM_W-1:0];
            default:  ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bpg_region_match.sv
module bpg_region_match
  import bpg_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        mode,
  input  logic [1:0]        acc_type,
  input  logic [AW-1:0]     rgn_lo   [NREG],
  input  logic [AW-1:0]     rgn_hi   [NREG],
  input  logic [PERM_W-1:0] rgn_perm [NREG],
  output logic              found,
  output logic              granted
);
  logic [NREG-1:0]   hit;
  logic [IDX_W-1:0]  sel;
  logic [PERM_W-1:0] sel_perm;
  logic [2:0]        mode_bits;

  // R4: inclusive bounds, enable gate, one comparator pair per region
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = rgn_perm[g][ENA_BIT] &&
                    (addr >= rgn_lo[g]) && (addr <= rgn_hi[g]);
  end

  // R5: scan from the top so the lowest matching index is the last written
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign sel_perm = rgn_perm[sel];

  // R6: three bits per mode, read at +0, write at +1, execute at +2
  always_comb begin
    case (mode)
      2'd0:    mode_bits = sel_perm[2:0];
      2'd1:    mode_bits = sel_perm[5:3];
      2'd2:    mode_bits = sel_perm[8:6];
      default: mode_bits = sel_perm[11:9];
    endcase
  end

  always_comb begin
    case (acc_type)
      ACC_RD:  granted = found && mode_bits[0];
      ACC_WR:  granted = found && mode_bits[1];
      ACC_EX:  granted = found && mode_bits[2];
      default: granted = 1'b0;
    endcase
  end
endmodule

// File: rtl/bpg_viol_rec.sv
module bpg_viol_rec
  import bpg_pkg::*;
#(
  parameter int AW    = 32,
  parameter int MID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             viol,
  input  logic [MID_W-1:0] viol_mid,
  input  logic [1:0]       viol_mode,
  input  logic [AW-1:0]    viol_addr,
  input  logic [1:0]       viol_reason,
  input  logic             rec_clr,
  input  logic             irq_en,
  output logic             irq,
  output logic             rec_valid,
  output logic             rec_ovf,
  output logic [MID_W-1:0] rec_mid,
  output logic [1:0]       rec_mode,
  output logic [AW-1:0]    rec_addr,
  output logic [1:0]       rec_reason
);
  logic take;

  // R8: capture into an empty record, or into one being cleared this cycle
  assign take = viol && (!rec_valid || rec_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_ovf   <= 1'b0;
    end else if (rec_clr) begin
      rec_valid <= viol;
      rec_ovf   <= 1'b0;
    end else if (viol) begin
      if (rec_valid) rec_ovf <= 1'b1;
      rec_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_mid    <= '0;
      rec_mode   <= '0;
      rec_addr   <= '0;
      rec_reason <= RSN_NONE;
    end else if (take) begin
      rec_mid    <= viol_mid;
      rec_mode   <= viol_mode;
      rec_addr   <= viol_addr;
      rec_reason <= viol_reason;
    end
  end

  // R9: level interrupt gated by the enable
  assign irq = irq_en && rec_valid;
endmodule

// File: rtl/bus_perm_guard.sv
module bus_perm_guard
  import bpg_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          MID_W      = 4,
  parameter int          NREG       = 16,
  parameter logic [31:0] BOOTROM_LO = 32'h4000_0000,
  parameter logic [31:0] BOOTROM_HI = 32'h4001_FFFF,
  parameter logic [31:0] ISRAM_LO   = 32'h4080_0000,
  parameter logic [31:0] ISRAM_HI   = 32'h408F_FFFF,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_field,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             req_valid,
  input  logic [MID_W-1:0] req_mid,
  input  logic             req_is_cpu,
  input  logic             req_cpu_machine,
  input  logic [1:0]       req_mode,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_type,
  input  logic             req_pmp_ok,
  output logic             dec_allow,
  output logic             dec_deny,
  input  logic             irq_en,
  input  logic             rec_clr,
  output logic             irq,
  output logic             rec_valid,
  output logic             rec_ovf,
  output logic [MID_W-1:0] rec_mid,
  output logic [1:0]       rec_mode,
  output logic [AW-1:0]    rec_addr,
  output logic [1:0]       rec_reason
);
  logic [1:0]        eff_mode;
  logic [AW-1:0]     rgn_lo   [NREG];
  logic [AW-1:0]     rgn_hi   [NREG];
  logic [PERM_W-1:0] rgn_perm [NREG];
  logic              found;
  logic              granted;
  logic              bypass;
  logic              run_check;
  logic              viol;

  bpg_mode_sel u_mode (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_we          (cfg_we),
    .cfg_field       (cfg_field),
    .cfg_mode        (cfg_wdata[1:0]),
    .req_is_cpu      (req_is_cpu),
    .req_cpu_machine (req_cpu_machine),
    .req_mode        (req_mode),
    .eff_mode        (eff_mode)
  );

  bpg_region_file #(.AW(AW), .NREG(NREG)) u_rfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .rgn_lo    (rgn_lo),
    .rgn_hi    (rgn_hi),
    .rgn_perm  (rgn_perm)
  );

  bpg_region_match #(.AW(AW), .NREG(NREG)) u_match (
    .addr     (req_addr),
    .mode     (eff_mode),
    .acc_type (req_type),
    .rgn_lo   (rgn_lo),
    .rgn_hi   (rgn_hi),
    .rgn_perm (rgn_perm),
    .found    (found),
    .granted  (granted)
  );

  // R2: fixed windows that only need the CPU-side verdict
  assign bypass = ((req_addr >= AW'(BOOTROM_LO)) && (req_addr <= AW'(BOOTROM_HI))) ||
                  ((req_addr >= AW'(ISRAM_LO))   && (req_addr <= AW'(ISRAM_HI)));

  // R3: region check only runs after a passing CPU-side verdict
  assign run_check = req_valid && !bypass && req_pmp_ok;
  assign viol      = run_check && !granted;

  // R7: one verdict per valid request, same cycle
  always_comb begin
    if (!req_valid)  dec_allow = 1'b0;
    else if (bypass) dec_allow = req_pmp_ok;
    else             dec_allow = run_check && granted;
  end
  assign dec_deny = req_valid && !dec_allow;

  bpg_viol_rec #(.AW(AW), .MID_W(MID_W)) u_rec (
    .clk         (clk),
    .rst_n       (rst_n),
    .viol        (viol),
    .viol_mid    (req_mid),
    .viol_mode   (eff_mode),
    .viol_addr   (req_addr),
    .viol_reason (found ? RSN_PERM : RSN_NOREGION),
    .rec_clr     (rec_clr),
    .irq_en      (irq_en),
    .irq         (irq),
    .rec_valid   (rec_valid),
    .rec_ovf     (rec_ovf),
    .rec_mid     (rec_mid),
    .rec_mode    (rec_mode),
    .rec_addr    (rec_addr),
    .rec_reason  (rec_reason)
  );
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
  parameter int          AW         = 32,
  parameter int          MID_W      = 4,
  parameter logic [31:0] BOOTROM_LO = 32'h4000_0000,
  parameter logic [31:0] BOOTROM_HI = 32'h4001_FFFF,
  parameter logic [31:0] ISRAM_LO   = 32'h4080_0000,
  parameter logic [31:0] ISRAM_HI   = 32'h408F_FFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_is_cpu,
  input logic             req_cpu_machine,
  input logic [AW-1:0]    req_addr,
  input logic             req_pmp_ok,
  input logic             dec_allow,
  input logic             dec_deny,
  input logic             irq_en,
  input logic             rec_clr,
  input logic             irq,
  input logic             rec_valid,
  input logic [MID_W-1:0] rec_mid,
  input logic [1:0]       rec_mode,
  input logic [AW-1:0]    rec_addr
);
  logic in_fixed;
  logic chk_deny;

  assign in_fixed = ((req_addr >= AW'(BOOTROM_LO)) && (req_addr <= AW'(BOOTROM_HI))) ||
                    ((req_addr >= AW'(ISRAM_LO))   && (req_addr <= AW'(ISRAM_HI)));
  assign chk_deny = req_valid && dec_deny && req_pmp_ok && !in_fixed;

  assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (dec_allow ^ dec_deny));

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!dec_allow && !dec_deny));

  assert_pmp_fail_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_pmp_ok) |-> dec_deny);

  assert_pmp_fail_no_record_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_pmp_ok && !rec_valid && !rec_clr) |=> !rec_valid);

  assert_fixed_follows_pmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_fixed) |-> (dec_allow == req_pmp_ok));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_en && rec_valid));

  assert_record_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_clr) |=> (rec_valid && $stable(rec_addr) && $stable(rec_mid)));

  assert_first_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_deny && !rec_valid) |=> rec_valid);

  assert_machine_trusted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_deny && !rec_valid && !rec_clr && req_is_cpu && req_cpu_machine) |=> (rec_mode == 2'd0));
endmodule

bind bus_perm_guard bpg_checker #(
  .AW(AW), .MID_W(MID_W),
  .BOOTROM_LO(BOOTROM_LO), .BOOTROM_HI(BOOTROM_HI),
  .ISRAM_LO(ISRAM_LO), .ISRAM_HI(ISRAM_HI)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_is_cpu      (req_is_cpu),
  .req_cpu_machine (req_cpu_machine),
  .req_addr        (req_addr),
  .req_pmp_ok      (req_pmp_ok),
  .dec_allow       (dec_allow),
  .dec_deny        (dec_deny),
  .irq_en          (irq_en),
  .rec_clr         (rec_clr),
  .irq             (irq),
  .rec_valid       (rec_valid),
  .rec_mid         (rec_mid),
  .rec_mode        (rec_mode),
  .rec_addr        (rec_addr)
);

// File: tb/tb_bus_perm_guard.sv
module tb_bus_perm_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_mid = '0;
  logic        req_is_cpu = 1'b0;
  logic        req_cpu_machine = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_type = '0;
  logic        req_pmp_ok = 1'b0;
  logic        irq_en = 1'b0;
  logic        rec_clr = 1'b0;
  logic        dec_allow, dec_deny, irq, rec_valid, rec_ovf;
  logic [3:0]  rec_mid;
  logic [1:0]  rec_mode, rec_reason;
  logic [31:0] rec_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_perm_guard dut (.*);

  typedef struct packed {
    logic        cpu;
    logic        mach;
    logic [1:0]  mode;
    logic [31:0] addr;
    logic [1:0]  typ;
    logic        pmp;
    logic        exp_allow;
  } vec_t;

  // expected verdicts worked out from the region setup below
  localparam vec_t VECS [16] = '{
    '{1'b0, 1'b0, 2'd0, 32'h6000_0010, 2'd1, 1'b1, 1'b1}, // R6 mode0 write granted
    '{1'b0, 1'b0, 2'd1, 32'h6000_0010, 2'd1, 1'b1, 1'b0}, // R6 mode1 has read only
    '{1'b0, 1'b0, 2'd1, 32'h6000_0010, 2'd0, 1'b1, 1'b1}, // R6 mode1 read
    '{1'b0, 1'b0, 2'd2, 32'h6000_0FFF, 2'd1, 1'b1, 1'b1}, // R4 inclusive end
    '{1'b0, 1'b0, 2'd3, 32'h6000_0800, 2'd0, 1'b1, 1'b0}, // R5 region0 wins
    '{1'b0, 1'b0, 2'd3, 32'h6000_1000, 2'd0, 1'b1, 1'b1}, // R5 only region1
    '{1'b0, 1'b0, 2'd0, 32'h5FFF_FFFF, 2'd0, 1'b1, 1'b0}, // R4 below any start
    '{1'b0, 1'b0, 2'd0, 32'h3000_0000, 2'd0, 1'b1, 1'b0}, // R4 disabled region
    '{1'b0, 1'b0, 2'd3, 32'h4000_1000, 2'd1, 1'b1, 1'b1}, // R2 boot ROM
    '{1'b0, 1'b0, 2'd3, 32'h4000_1000, 2'd1, 1'b0, 1'b0}, // R2 boot ROM, pmp fail
    '{1'b0, 1'b0, 2'd3, 32'h408F_FFFF, 2'd2, 1'b1, 1'b1}, // R2 SRAM top
    '{1'b0, 1'b0, 2'd0, 32'h6000_0010, 2'd0, 1'b0, 1'b0}, // R3 pmp fail
    '{1'b1, 1'b1, 2'd3, 32'h2000_0000, 2'd2, 1'b1, 1'b1}, // R1 machine is trusted
    '{1'b1, 1'b0, 2'd0, 32'h2000_0000, 2'd2, 1'b1, 1'b0}, // R1 user mode 2
    '{1'b0, 1'b0, 2'd0, 32'h6000_0010, 2'd3, 1'b1, 1'b0}, // R6 type 3 never granted
    '{1'b0, 1'b0, 2'd1, 32'h6000_1000, 2'd2, 1'b1, 1'b1}  // R6 region1 execute
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] idx, input logic [1:0] fld, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives a request at a falling edge; the verdict is read 2 ns later
  task automatic put_req(input logic cpu, input logic mach, input logic [1:0] mode,
                         input logic [3:0] mid, input logic [31:0] addr,
                         input logic [1:0] typ, input logic pmp);
    @(negedge clk);
    req_valid = 1'b1; req_is_cpu = cpu; req_cpu_machine = mach; req_mode = mode;
    req_mid = mid; req_addr = addr; req_type = typ; req_pmp_ok = pmp;
    #2;
  endtask

  // releases the request at the next falling edge, after the capturing rise
  task automatic drop_req();
    @(negedge clk);
    req_valid = 1'b0;
    rec_clr = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    rec_clr = 1'b1;
    @(negedge clk);
    rec_clr = 1'b0;
  endtask

  initial begin
    #500us;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R7 reset allow", dec_allow, 0);
    check("R7 reset deny", dec_deny, 0);
    check("R8 reset rec_valid", rec_valid, 0);
    check("R9 reset irq", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: no region is enabled after reset
    put_req(1'b0, 1'b0, 2'd0, 4'd1, 32'h6000_0010, 2'd0, 1'b1);
    check("R4 reset regions deny", dec_deny, 1);
    drop_req();
    check("R4 reset reason no-region", rec_reason, 2'd1);
    pulse_clear();

    // R10: region setup through the write port
    cfg_write(4'd0, 2'd0, 32'h6000_0000);
    cfg_write(4'd0, 2'd1, 32'h6000_0FFF);
    cfg_write(4'd0, 2'd2, 32'h0000_10CF);
    cfg_write(4'd1, 2'd0, 32'h6000_0000);
    cfg_write(4'd1, 2'd1, 32'h6000_FFFF);
    cfg_write(4'd1, 2'd2, 32'h0000_1FFF);
    cfg_write(4'd2, 2'd0, 32'h2000_0000);
    cfg_write(4'd2, 2'd1, 32'h2000_00FF);
    cfg_write(4'd2, 2'd2, 32'h0000_1004);
    cfg_write(4'd15, 2'd0, 32'h3000_0000);
    cfg_write(4'd15, 2'd1, 32'h3000_000F);
    cfg_write(4'd15, 2'd2, 32'h0000_0FFF);
    cfg_write(4'd0, 2'd3, 32'h0000_0002);

    for (int i = 0; i < 16; i++) begin
      put_req(VECS[i].cpu, VECS[i].mach, VECS[i].mode, 4'd3,
              VECS[i].addr, VECS[i].typ, VECS[i].pmp);
      check($sformatf("R7 vector %0d allow", i), dec_allow, VECS[i].exp_allow);
      check($sformatf("R7 vector %0d deny", i), dec_deny, !VECS[i].exp_allow);
      drop_req();
      pulse_clear();
    end

    // R3: pmp failure outside the fixed windows leaves no record
    put_req(1'b0, 1'b0, 2'd0, 4'd2, 32'h5000_0000, 2'd0, 1'b0);
    drop_req();
    check("R3 no record on pmp fail", rec_valid, 0);
    // R2: a denied fixed-window access leaves no record either
    put_req(1'b0, 1'b0, 2'd3, 4'd2, 32'h4080_0000, 2'd1, 1'b0);
    drop_req();
    check("R2 no record in fixed window", rec_valid, 0);

    // R8/R1: first violation is a user-mode CPU execute in mode 2
    put_req(1'b1, 1'b0, 2'd0, 4'd5, 32'h2000_0010, 2'd2, 1'b1);
    check("R8 record still empty before edge", rec_valid, 0);
    drop_req();
    check("R8 record valid", rec_valid, 1);
    check("R8 record mid", rec_mid, 4'd5);
    check("R1 record user mode", rec_mode, 2'd2);
    check("R8 record addr", rec_addr, 32'h2000_0010);
    check("R6 reason permission", rec_reason, 2'd2);
    check("R9 irq off while disabled", irq, 0);
    irq_en = 1'b1;
    #1;
    check("R9 irq on when enabled", irq, 1);

    // R8: second violation only sets overflow
    put_req(1'b0, 1'b0, 2'd0, 4'd7, 32'h5000_0000, 2'd0, 1'b1);
    drop_req();
    check("R8 overflow set", rec_ovf, 1);
    check("R8 addr kept", rec_addr, 32'h2000_0010);
    check("R8 mid kept", rec_mid, 4'd5);

    // R8: clear together with a new violation captures it fresh
    put_req(1'b1, 1'b1, 2'd0, 4'd9, 32'h5000_0004, 2'd0, 1'b1);
    rec_clr = 1'b1;
    drop_req();
    check("R8 fresh record valid", rec_valid, 1);
    check("R8 fresh overflow clear", rec_ovf, 0);
    check("R8 fresh addr", rec_addr, 32'h5000_0004);
    check("R1 machine mode recorded", rec_mode, 2'd0);
    check("R4 reason no-region", rec_reason, 2'd1);
    pulse_clear();
    check("R8 cleared", rec_valid, 0);
    check("R9 irq drops after clear", irq, 0);

    // R1: writing 0 to the user-mode register yields mode 1
    cfg_write(4'd0, 2'd3, 32'h0000_0000);
    put_req(1'b1, 1'b0, 2'd3, 4'd4, 32'h6000_0010, 2'd1, 1'b1);
    check("R1 user mode 1 write denied", dec_deny, 1);
    drop_req();
    check("R1 zero stored as mode 1", rec_mode, 2'd1);
    pulse_clear();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule